// File: doc/BRIEF.md
# CAN Receive Buffer Status Flags

This block keeps the receive-side status bits for a bank of CAN message buffers (sixteen by default). A frame engine, which lies outside this block, signals each reception that passed acceptance filtering. It does so with a one-cycle pulse that carries the target buffer index and a flag telling whether the frame was a remote frame. For each buffer, the block records that a reception completed, whether the last frame was a remote request, and whether a new frame landed while the previous one was still unread.

Software reaches the flags through a small register port. That port also holds a per-buffer enable bit, a per-buffer interrupt-enable bit and a global halt bit. A buffer accepts frames only while it is enabled and the controller is not halted. Software clears the completion and overrun flags by writing zero to their bits. A single registered interrupt line goes high while any enabled buffer has a completed reception waiting.

Top module: `can_rx_flags`

## Requirements
- R1: After reset every per-buffer flag and enable bit reads 0, the halt bit reads 1, and `rx_irq` is 0.
- R2: While the halt bit is 1, a reception pulse changes no flag.
- R3: A reception pulse aimed at a buffer whose enable bit is 0 changes no flag.
- R4: An accepted reception (pulse present, halt 0, buffer enabled) sets that buffer's completion flag one cycle later.
- R5: On an accepted reception, the buffer's remote flag becomes 1 for a remote frame and 0 for a data frame; software writes to the remote register are ignored.
- R6: An accepted reception into a buffer whose completion flag is already 1 sets that buffer's overrun flag.
- R7: Writing 0 to a bit of the completion or overrun register clears that bit; writing 1 leaves it unchanged.
- R8: When a hardware set and a software clear of the same completion or overrun bit fall in the same cycle, the bit ends up 1.
- R9: `rx_irq` equals the OR over all buffers of (completion flag AND interrupt enable), taken from the flag values one clock earlier.
- R10: An overrun flag stays 1 until software writes 0 to it, whatever the receptions and completion clears in between.
- R11: Register map on `reg_addr`: 0 halt (bit 0), 1 enable, 2 completion, 3 remote, 4 overrun, 5 interrupt enable; bit n of registers 1 to 5 belongs to buffer n. Registers 0, 1 and 5 are plain read/write. Addresses 6 and 7 read 0 and ignore writes. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle pulse: a filtered frame was received |
| rx_idx | input | 4 | Target buffer of the reception |
| rx_remote | input | 1 | 1 for a remote frame, 0 for a data frame |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| rx_irq | output | 1 | Registered combined receive interrupt |

## Verification
The assertions assume that `rx_valid` lasts a single cycle per reception and that `rx_idx` names a buffer that exists. They also assume that a register write and a reception may coincide freely, since the hardware-wins rule covers that case. The stimulus drives `rx_idx` only below the buffer count and raises each pulse for one cycle. It deliberately places receptions, completion clears and halt or enable changes in the same cycle, so that the priority and old-value rules are exercised.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_HALT = 3'd0,
    SEL_EN   = 3'd1,
    SEL_CMP  = 3'd2,
    SEL_REM  = 3'd3,
    SEL_OVR  = 3'd4,
    SEL_IE   = 3'd5
  } reg_sel_e;

  // sticky bit: hardware set wins over a software clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/can_rx_slot.sv
module can_rx_slot
  import can_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic remote,
  input  logic clr_cmp,
  input  logic clr_ovr,
  output logic cmp,
  output logic rem,
  output logic ovr
);
  logic ovr_evt;
  assign ovr_evt = hit & cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= 1'b0;
      rem <= 1'b0;
      ovr <= 1'b0;
    end else begin
      cmp <= sticky_next(cmp, hit, clr_cmp);
      ovr <= sticky_next(ovr, ovr_evt, clr_ovr);
      if (hit) rem <= remote;
    end
  end

  assert_cmp_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cmp);
  assert_rem_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (rem == $past(remote)));
  assert_ovr_on_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmp) |=> ovr);
  assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_ovr) |=> ovr);
  assert_cmp_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !$rose(cmp));
endmodule

// File: rtl/can_rx_ctrl.sv
module can_rx_ctrl
  import can_rx_pkg::*;
#(
  parameter int NBUF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBUF-1:0]   wdata,
  input  logic [NBUF-1:0]   cmp,
  input  logic [NBUF-1:0]   rem,
  input  logic [NBUF-1:0]   ovr,
  output logic              halt,
  output logic [NBUF-1:0]   en,
  output logic [NBUF-1:0]   ie,
  output logic [NBUF-1:0]   rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b1;
      en   <= '0;
      ie   <= '0;
    end else if (wen) begin
      case (addr)
        SEL_HALT: halt <= wdata[0];
        SEL_EN:   en   <= wdata;
        SEL_IE:   ie   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      SEL_HALT: rdata = {{(NBUF-1){1'b0}}, halt};
      SEL_EN:   rdata = en;
      SEL_CMP:  rdata = cmp;
      SEL_REM:  rdata = rem;
      SEL_OVR:  rdata = ovr;
      SEL_IE:   rdata = ie;
      default:  rdata = '0;
    endcase
  end

  assert_halt_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr == SEL_HALT) |=> (halt == $past(wdata[0])));
endmodule

// File: rtl/can_rx_flags.sv
module can_rx_flags
  import can_rx_pkg::*;
#(
  parameter int NBUF  = 16,
  localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic              rx_remote,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NBUF-1:0]   reg_wdata,
  output logic [NBUF-1:0]   reg_rdata,
  output logic              rx_irq
);
  logic            halt;
  logic [NBUF-1:0] en, ie, cmp, rem, ovr;
  logic [NBUF-1:0] hit, clr_cmp, clr_ovr;
  logic            rx_accept;
  logic            irq_req;

  assign rx_accept = rx_valid && !halt && (32'(rx_idx) < NBUF) && en[rx_idx];
  assign irq_req   = |(cmp & ie);

  can_rx_ctrl #(.NBUF(NBUF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .cmp(cmp), .rem(rem), .ovr(ovr),
    .halt(halt), .en(en), .ie(ie), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    assign hit[i]     = rx_accept && (rx_idx == IDX_W'(i));
    assign clr_cmp[i] = reg_wen && (reg_addr == SEL_CMP) && !reg_wdata[i];
    assign clr_ovr[i] = reg_wen && (reg_addr == SEL_OVR) && !reg_wdata[i];
    can_rx_slot u_slot (
      .clk(clk), .rst_n(rst_n), .hit(hit[i]), .remote(rx_remote),
      .clr_cmp(clr_cmp[i]), .clr_ovr(clr_ovr[i]),
      .cmp(cmp[i]), .rem(rem[i]), .ovr(ovr[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= irq_req;
  end

  assert_halt_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && halt && !reg_wen) |=> ($stable(cmp) && $stable(rem) && $stable(ovr)));
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |=> !rx_irq);
  assert_one_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/can_rx_flags_test.sv
`timescale 1ns/100ps
module can_rx_flags_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         rx_valid = 0, rx_remote = 0, reg_wen = 0;
  logic [3:0]   rx_idx = '0;
  logic [2:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         rx_irq;

  can_rx_flags #(.NBUF(N)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_idx(rx_idx),
    .rx_remote(rx_remote), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq)
  );

  int checks = 0, errors = 0;
  logic [N-1:0] m_en, m_ie, m_cmp, m_rem, m_ovr;
  logic m_halt, m_irq;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] exp, input string tag);
    reg_addr = a;
    #0.2;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic check_all(input string tag);
    rd(3'd0, {{(N-1){1'b0}}, m_halt}, {tag, " R11 halt"});
    rd(3'd1, m_en,  {tag, " R11 enable"});
    rd(3'd2, m_cmp, {tag, " completion"});
    rd(3'd3, m_rem, {tag, " remote"});
    rd(3'd4, m_ovr, {tag, " overrun"});
    rd(3'd5, m_ie,  {tag, " R11 irq-enable"});
    rd(3'd6, '0,    {tag, " R11 unused"});
  endtask

  // one clock: drive at negedge, update reference at posedge, compare irq at next negedge
  task automatic cycle(input bit ev, input int idx, input bit remote,
                       input bit we, input logic [2:0] a, input logic [N-1:0] d);
    logic [N-1:0] n_en, n_ie, n_cmp, n_rem, n_ovr;
    logic n_halt, n_irq;
    bit hit;
    rx_valid = ev; rx_idx = 4'(idx); rx_remote = remote;
    reg_wen = we; reg_addr = a; reg_wdata = d;
    hit = ev && !m_halt && m_en[idx];
    n_irq = 1'b0;
    for (int k = 0; k < N; k++) if (m_cmp[k] && m_ie[k]) n_irq = 1'b1;
    n_en = m_en; n_ie = m_ie; n_cmp = m_cmp; n_rem = m_rem; n_ovr = m_ovr; n_halt = m_halt;
    if (we) begin
      if (a == 3'd0) n_halt = d[0];
      if (a == 3'd1) n_en = d;
      if (a == 3'd5) n_ie = d;
      for (int k = 0; k < N; k++) begin
        if (a == 3'd2 && d[k] == 1'b0) n_cmp[k] = 1'b0;
        if (a == 3'd4 && d[k] == 1'b0) n_ovr[k] = 1'b0;
      end
    end
    if (hit) begin
      if (m_cmp[idx]) n_ovr[idx] = 1'b1;
      n_cmp[idx] = 1'b1;
      n_rem[idx] = remote;
    end
    @(posedge clk);
    m_en = n_en; m_ie = n_ie; m_cmp = n_cmp; m_rem = n_rem; m_ovr = n_ovr;
    m_halt = n_halt; m_irq = n_irq;
    @(negedge clk);
    rx_valid = 0; reg_wen = 0;
    chk("R9 rx_irq", {{(N-1){1'b0}}, rx_irq}, {{(N-1){1'b0}}, m_irq});
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 3'd0, '0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_en = '0; m_ie = '0; m_cmp = '0; m_rem = '0; m_ovr = '0; m_halt = 1'b1; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    chk("R1 irq", {{(N-1){1'b0}}, rx_irq}, '0);

    // R2: halted, buffer 3 enabled, reception ignored
    cycle(0, 0, 0, 1, 3'd1, 16'h0009);
    cycle(0, 0, 0, 1, 3'd5, 16'h0008);
    cycle(1, 3, 1, 0, 3'd0, '0);
    check_all("R2 halted");

    // leave halt; R3: buffer 5 disabled
    cycle(0, 0, 0, 1, 3'd0, '0);
    cycle(1, 5, 1, 0, 3'd0, '0);
    check_all("R3 disabled");

    // R4: data frame into buffer 3; irq follows one cycle later (R9)
    cycle(1, 3, 0, 0, 3'd0, '0);
    check_all("R4 complete");
    idle();
    // R5/R6: remote frame while pending
    cycle(1, 3, 1, 0, 3'd0, '0);
    check_all("R5 R6 overrun");
    // R7: writing ones leaves flags; remote register is read-only
    cycle(0, 0, 0, 1, 3'd2, 16'hFFFF);
    cycle(0, 0, 0, 1, 3'd4, 16'hFFFF);
    cycle(0, 0, 0, 1, 3'd3, 16'h0000);
    check_all("R7 write ones");
    // R7/R10: clear completion only; overrun stays
    cycle(0, 0, 0, 1, 3'd2, 16'hFFF7);
    check_all("R10 ovr sticky");
    idle();
    // R8: set then set+clear in same cycle
    cycle(1, 0, 0, 0, 3'd0, '0);
    cycle(1, 0, 1, 1, 3'd2, 16'h0000);
    check_all("R8 hw wins");
    cycle(1, 0, 0, 1, 3'd4, 16'h0000);
    check_all("R8 ovr hw wins");
    cycle(0, 0, 0, 1, 3'd4, 16'h0000);
    check_all("R7 ovr clear");

    // mixed stimulus compared every clock
    for (int it = 0; it < 400; it++) begin
      int r = $urandom_range(0, 9);
      bit ev = ($urandom_range(0, 2) != 0);
      int idx = $urandom_range(0, N - 1);
      bit rem = $urandom_range(0, 1) != 0;
      logic [N-1:0] d = N'($urandom);
      if (r == 0)      cycle(ev, idx, rem, 1, 3'd0, (it % 50 == 0) ? N'(1) : N'(0));
      else if (r == 1) cycle(ev, idx, rem, 1, 3'd1, d | 16'h00FF);
      else if (r == 2) cycle(ev, idx, rem, 1, 3'd2, d | 16'h5555);
      else if (r == 3) cycle(ev, idx, rem, 1, 3'd4, d | 16'hAAAA);
      else if (r == 4) cycle(ev, idx, rem, 1, 3'd5, d);
      else if (r == 5) cycle(ev, idx, rem, 1, 3'($urandom_range(3, 7)), d);
      else             cycle(ev, idx, rem, 0, 3'd0, '0);
      check_all("R11 mixed");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule